// File: doc/BRIEF.md
# Dual-Channel Maskable Interrupt Combiner

This block merges level interrupt requests from two disk-interface channels into one shared level interrupt line. Each channel's request level is captured as a pending flag, and each channel has a block flag that masks it. Both kinds of flag sit in a single 8-bit mode byte. A host register port reads the byte and can write only its two block bits.

The shared output is registered. It rises one clock after a channel's request rises while that channel is unblocked, and it falls one clock after the last unblocked pending flag goes away. It also falls one clock after the host blocks the only active channel. When a request change and a host write land in the same cycle, the output is computed from both new values.

Top module: `ide_irq_combiner`

## Requirements
- R1: Synchronous active-high reset clears the whole mode byte to 0x00 and drives `irq_out` low.
- R2: Mode-byte bit 2 is the channel-0 pending flag. One clock after `chan_req[0]` is sampled high it reads 1, and one clock after it is sampled low it reads 0.
- R3: Mode-byte bit 3 is the channel-1 pending flag and follows `chan_req[1]` in the same way.
- R4: Bit 4 is the channel-0 block flag and bit 5 is the channel-1 block flag. A host write (`wr_en` high) loads `wr_data[5:4]` into them. Without a write they hold their value.
- R5: Mode-byte bits 1:0 and 7:6 always read 0, whatever is written.
- R6: `irq_out` equals (bit2 AND NOT bit4) OR (bit3 AND NOT bit5) of the mode byte that is visible in the same cycle. Both update on the same clock edge.
- R7: When a request change and a host write occur in the same cycle, one clock later both the mode byte and `irq_out` reflect both changes.
- R8: Host writes to bits 3:2 have no effect. The pending flags follow only the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_req | input | 2 | Level interrupt request per channel (bit n = channel n) |
| wr_en | input | 1 | Host write strobe for the mode byte |
| wr_data | input | 8 | Host write data; only bits 5:4 are used |
| mode_rd | output | 8 | Current mode byte as read by the host |
| irq_out | output | 1 | Combined registered interrupt level |

## Verification
The assertions check the following on every cycle: the pending flags track the previous cycle's request levels, the block flags change only on a write and then take the written value, the reserved bits stay zero, and the output agrees with the mode byte shown beside it. Other behaviour can only be shown by the bench's scenarios. These include reset values, the exact one-cycle latency from a request edge to the output, a block write that masks a channel which is already pending, and a write that coincides with a request edge. The bench covers these with directed sequences and then with seeded random traffic checked against a reference model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int MODE_W   = 8;
  localparam int NUM_CH   = 2;
  localparam int PEND_LSB = 2;
  localparam int BLK_LSB  = 4;

  function automatic logic combine(input logic [NUM_CH-1:0] pend,
                                   input logic [NUM_CH-1:0] blk);
    return |(pend & ~blk);
  endfunction
endpackage

// File: rtl/irqc_pend_track.sv
module irqc_pend_track #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req,
  output logic [NUM_CH-1:0] pend_d,
  output logic [NUM_CH-1:0] pend_q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign pend_d[c] = req[c];
    always_ff @(posedge clk) begin
      if (rst) pend_q[c] <= 1'b0;
      else     pend_q[c] <= pend_d[c];
    end
  end
endmodule

// File: rtl/irqc_block_reg.sv
module irqc_block_reg #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] wr_bits,
  output logic [NUM_CH-1:0] blk_d,
  output logic [NUM_CH-1:0] blk_q
);
  always_comb blk_d = wr_en ? wr_bits : blk_q;

  always_ff @(posedge clk) begin
    if (rst) blk_q <= '0;
    else     blk_q <= blk_d;
  end
endmodule

// File: rtl/irqc_level_eval.sv
module irqc_level_eval #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pend_d,
  input  logic [NUM_CH-1:0] blk_d,
  output logic              irq_q
);
  // Evaluated from next-state values so the line moves with the mode byte.
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irqc_pkg::combine(pend_d, blk_d);
  end
endmodule

// File: rtl/ide_irq_combiner.sv
module ide_irq_combiner #(
  parameter int MODE_W   = irqc_pkg::MODE_W,
  parameter int NUM_CH   = irqc_pkg::NUM_CH,
  parameter int PEND_LSB = irqc_pkg::PEND_LSB,
  parameter int BLK_LSB  = irqc_pkg::BLK_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] chan_req,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output logic [MODE_W-1:0] mode_rd,
  output logic              irq_out
);
  logic [NUM_CH-1:0] pend_d, pend_q, blk_d, blk_q;

  irqc_pend_track #(.NUM_CH(NUM_CH)) pend_i (
    .clk(clk), .rst(rst), .req(chan_req), .pend_d(pend_d), .pend_q(pend_q)
  );

  irqc_block_reg #(.NUM_CH(NUM_CH)) blk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_bits(wr_data[BLK_LSB +: NUM_CH]), .blk_d(blk_d), .blk_q(blk_q)
  );

  irqc_level_eval #(.NUM_CH(NUM_CH)) eval_i (
    .clk(clk), .rst(rst), .pend_d(pend_d), .blk_d(blk_d), .irq_q(irq_out)
  );

  always_comb begin
    mode_rd = '0;
    mode_rd[PEND_LSB +: NUM_CH] = pend_q;
    mode_rd[BLK_LSB  +: NUM_CH] = blk_q;
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int MODE_W   = 8,
  parameter int NUM_CH   = 2,
  parameter int PEND_LSB = 2,
  parameter int BLK_LSB  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] chan_req,
  input logic              wr_en,
  input logic [MODE_W-1:0] wr_data,
  input logic [MODE_W-1:0] mode_rd,
  input logic              irq_out
);
  localparam logic [MODE_W-1:0] USED_MASK =
    MODE_W'(((1 << NUM_CH) - 1) << PEND_LSB) | MODE_W'(((1 << NUM_CH) - 1) << BLK_LSB);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  AST_PEND_FOLLOW: assert property (@(posedge clk) disable iff (rst || !armed)
    mode_rd[PEND_LSB +: NUM_CH] == $past(chan_req)); // R2 R3 R8

  AST_BLK_LOAD: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(wr_en) |-> mode_rd[BLK_LSB +: NUM_CH] == $past(wr_data[BLK_LSB +: NUM_CH])); // R4

  AST_BLK_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(wr_en) |-> $stable(mode_rd[BLK_LSB +: NUM_CH])); // R4

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst || !armed)
    (mode_rd & ~USED_MASK) == '0); // R5

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst || !armed)
    irq_out == |(mode_rd[PEND_LSB +: NUM_CH] & ~mode_rd[BLK_LSB +: NUM_CH])); // R6 R7
endmodule

bind ide_irq_combiner irqc_checker #(
  .MODE_W(MODE_W), .NUM_CH(NUM_CH), .PEND_LSB(PEND_LSB), .BLK_LSB(BLK_LSB)
) chk_i (
  .clk(clk), .rst(rst), .chan_req(chan_req), .wr_en(wr_en),
  .wr_data(wr_data), .mode_rd(mode_rd), .irq_out(irq_out)
);

// File: tb/ide_irq_combiner_tb.sv
module ide_irq_combiner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int N_RANDOM   = 400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] chan_req = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] mode_rd;
  logic       irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [1:0] m_blk = '0;
  logic [1:0] m_pend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_irq_combiner dut_i (
    .clk(clk), .rst(rst), .chan_req(chan_req), .wr_en(wr_en),
    .wr_data(wr_data), .mode_rd(mode_rd), .irq_out(irq_out)
  );

  function automatic logic [7:0] exp_mode(input logic [1:0] pend, input logic [1:0] blk);
    return {2'b00, blk, pend, 2'b00};
  endfunction

  function automatic logic exp_irq(input logic [1:0] pend, input logic [1:0] blk);
    return (pend[0] & ~blk[0]) | (pend[1] & ~blk[1]);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Drive after a negedge, clock once, sample at the following negedge.
  task automatic step(input logic [1:0] req, input logic we, input logic [7:0] wd,
                      input string tag);
    chan_req = req;
    wr_en    = we;
    wr_data  = wd;
    m_pend   = req;
    if (we) m_blk = wd[5:4];
    @(posedge clk);
    @(negedge clk);
    check({tag, " mode"}, mode_rd, exp_mode(m_pend, m_blk));
    check({tag, " irq"}, {7'b0, irq_out}, {7'b0, exp_irq(m_pend, m_blk)});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    chan_req = 2'b11;
    wr_en = 1'b1;
    wr_data = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset dominates active inputs
    check("R1 reset mode", mode_rd, 8'h00);
    check("R1 reset irq", {7'b0, irq_out}, 8'h00);
    rst = 1'b0;
    m_blk = '0;

    step(2'b00, 1'b0, 8'h00, "R1 idle");
    step(2'b01, 1'b0, 8'h00, "R2 ch0 rise");          // bit2 set, irq high
    step(2'b00, 1'b0, 8'h00, "R2 ch0 fall");
    step(2'b10, 1'b0, 8'h00, "R3 ch1 rise");          // bit3 set
    step(2'b11, 1'b1, 8'h10, "R4 block ch0");         // ch1 still drives irq
    step(2'b01, 1'b0, 8'h00, "R6 ch0 blocked only");  // irq low
    step(2'b01, 1'b0, 8'h00, "R4 block hold");
    step(2'b01, 1'b1, 8'hFF, "R5 write all ones");    // only 5:4 land
    step(2'b01, 1'b1, 8'hCF, "R8 write pend bits");   // block cleared, bits 3:2 ignored
    step(2'b00, 1'b1, 8'h0C, "R8 pend write req low");
    step(2'b10, 1'b1, 8'h20, "R7 rise with block");   // ch1 rises while blocked
    step(2'b01, 1'b1, 8'h00, "R7 swap and unblock");
    step(2'b11, 1'b1, 8'h30, "R7 both blocked");
    step(2'b11, 1'b1, 8'h20, "R6 unblock ch0");

    for (int i = 0; i < N_RANDOM; i++) begin
      logic [1:0] r;
      logic w;
      logic [7:0] d;
      r = 2'($urandom_range(0, 3));
      w = ($urandom_range(0, 3) == 0);
      d = 8'($urandom());
      step(r, w, d, "R6 R7 random");
    end

    // R1: reset mid-run clears the block flags as well
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 rerun mode", mode_rd, 8'h00);
    check("R1 rerun irq", {7'b0, irq_out}, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule